// File: doc/BRIEF.md
# Load Point Centring Synchronizer

This block sits on the fast side of a clock-domain crossing between a slower synchronous logic clock and a serializer clock. The slow side raises an enable pulse once per parallel word, at the instant it changes the word. The block brings that pulse into the fast domain, measures the spacing between the first two pulses it sees, and from then on fires a one-cycle parallel-load strobe halfway between pulses. Loading at the midpoint gives the word held across the boundary the widest setup and hold window on both sides.

The measurement is taken once and then frozen. After lock, a free-running phase counter of length equal to the measured period generates the strobe. Missing, late or early enable pulses do not disturb it, and only a reset starts a new measurement. A typical use is a 48-bit word fanned out over 4 serial lanes, so each lane shifts 12 bits per word. The block only sets the load instant. The shift registers themselves belong to the serializer.

Top module: `lpc_centre_sync`

## Requirements
- R1: `rst` is synchronous and active high. In the cycle after any clock edge that samples `rst` high, both `load_o` and `locked_o` are 0, including when the block was locked before.
- R2: `en_i` passes through a two-flop synchronizer followed by rising-edge detection. If `en_i` is first sampled high at clock edge k, the detection belongs to cycle k+2 (the cycle after edge k+2). A pulse held high for several cycles yields one detection.
- R3: The period P is the number of fast cycles from the first detection to the second detection. Accepted values run from 2 to 2^CNT_W-1.
- R4: If no second detection arrives within 2^CNT_W-1 cycles of the first, the measurement is dropped and does not lock. The next detection starts a fresh measurement.
- R5: When the second detection falls in cycle e, `locked_o` is 1 from cycle e+1 on. It stays 1 until reset.
- R6: `load_o` is high for exactly one cycle, in cycle e+floor(P/2), for the locking detection at cycle e. For a pulse sampled at edge k on the nominal schedule, that is cycle k+2+floor(P/2).
- R7: After lock, `load_o` repeats every P cycles whether or not enable pulses keep arriving.
- R8: After lock, the timing of later enable pulses is ignored. A pulse moved off its nominal slot does not move the strobe.
- R9: `load_o` never asserts while `locked_o` is 0, and it is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serializer clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable pulse from the slower domain, one per parallel word |
| load_o | output | 1 | One-cycle parallel-load strobe at the midpoint between pulses |
| locked_o | output | 1 | Set once the period has been measured, cleared only by reset |

## Verification
Every cycle, the assertions check four things. The strobe only appears while locked and is never two cycles wide. The locked flag never drops outside reset. Once two strobes have been seen, every later gap between strobes equals the first one. The exact placement of the strobe at half the period needs the bench, because it depends on the spacing of the stimulus and the synchronizer delay. The same holds for the discarded over-long first gap, for the free-running strobe through a dropped pulse, and for immunity to a displaced pulse. The bench's scenarios sweep the slow-to-fast ratio across odd, even, minimum and maximum periods.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  // measurement progress of the period counter
  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,   // waiting for the first detected edge
    MS_COUNT = 2'd1,   // counting cycles up to the second edge
    MS_HOLD  = 2'd2    // period frozen, no further measurement
  } meas_state_e;

  localparam int unsigned LPC_MIN_SYNC = 2;

endpackage

// File: rtl/lpc_pulse_sync.sv
module lpc_pulse_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);

  localparam int unsigned NST = (STAGES < lpc_pkg::LPC_MIN_SYNC) ?
                                lpc_pkg::LPC_MIN_SYNC : STAGES;

  logic [NST-1:0] chain_q;
  logic           last_q;
  logic           rise_q;

  // metastability chain; bit 0 is the first flop
  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[NST-2:0], async_i};
    end
  end

  // registered rising-edge detector on the settled bit
  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      last_q <= chain_q[NST-1];
      rise_q <= chain_q[NST-1] & ~last_q;
    end
  end

  assign rise_o = rise_q;

endmodule

// File: rtl/lpc_period_meas.sv
module lpc_period_meas
  import lpc_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_i,
  output logic             lock_now_o,
  output logic [CNT_W-1:0] period_o,
  output logic             locked_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  meas_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             locked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= MS_IDLE;
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      case (state_q)
        MS_IDLE: begin
          if (rise_i) begin
            state_q <= MS_COUNT;
            cnt_q   <= CNT_ONE;
          end
        end
        MS_COUNT: begin
          if (rise_i) begin
            state_q  <= MS_HOLD;
            locked_q <= 1'b1;
          end else if (cnt_q == CNT_MAX) begin
            // gap too long to represent: throw the measurement away
            state_q <= MS_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_ONE;
          end
        end
        MS_HOLD: begin
          state_q <= MS_HOLD;
        end
        default: begin
          state_q <= MS_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign lock_now_o = (state_q == MS_COUNT) && rise_i;
  assign period_o   = cnt_q;
  assign locked_o   = locked_q;

endmodule

// File: rtl/lpc_strobe_gen.sv
module lpc_strobe_gen #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_now_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             load_o
);

  localparam logic [CNT_W-1:0] PH_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             run_q;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] ph_q;
  logic             load_q;

  logic [CNT_W-1:0] per_use;
  logic [CNT_W-1:0] half_use;
  logic [CNT_W-1:0] ph_nxt;
  logic             active;

  // phase counts 0..P-1 with phase 0 on the locking detection cycle
  always_comb begin
    per_use  = lock_now_i ? period_i : per_q;
    half_use = per_use >> 1;
    active   = lock_now_i | run_q;
    if (lock_now_i) begin
      ph_nxt = PH_ONE;
    end else if (ph_q == per_q - PH_ONE) begin
      ph_nxt = '0;
    end else begin
      ph_nxt = ph_q + PH_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      per_q  <= '0;
      ph_q   <= '0;
      load_q <= 1'b0;
    end else begin
      if (lock_now_i) begin
        run_q <= 1'b1;
        per_q <= period_i;
      end
      if (active) begin
        ph_q <= ph_nxt;
      end
      load_q <= active && (ph_nxt == half_use);
    end
  end

  assign load_o = load_q;

endmodule

// File: rtl/lpc_centre_sync.sv
module lpc_centre_sync #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic load_o,
  output logic locked_o
);

  logic             rise;
  logic             lock_now;
  logic [CNT_W-1:0] period;

  lpc_pulse_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (en_i),
    .rise_o  (rise)
  );

  lpc_period_meas #(
    .CNT_W (CNT_W)
  ) u_meas (
    .clk        (clk),
    .rst        (rst),
    .rise_i     (rise),
    .lock_now_o (lock_now),
    .period_o   (period),
    .locked_o   (locked_o)
  );

  lpc_strobe_gen #(
    .CNT_W (CNT_W)
  ) u_strobe (
    .clk        (clk),
    .rst        (rst),
    .lock_now_i (lock_now),
    .period_i   (period),
    .load_o     (load_o)
  );

endmodule

// File: rtl/lpc_centre_sync_chk.sv
module lpc_centre_sync_chk (
  input logic clk,
  input logic rst,
  input logic load_o,
  input logic locked_o
);

  logic [31:0] since_q;
  logic [31:0] ref_q;
  logic        seen_q;
  logic        ref_v_q;

  // distance between strobes, first gap kept as reference
  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= '0;
      ref_q   <= '0;
      seen_q  <= 1'b0;
      ref_v_q <= 1'b0;
    end else if (load_o) begin
      seen_q  <= 1'b1;
      since_q <= 32'd1;
      if (seen_q && !ref_v_q) begin
        ref_q   <= since_q;
        ref_v_q <= 1'b1;
      end
    end else if (seen_q) begin
      since_q <= since_q + 32'd1;
    end
  end

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!locked_o && !load_o));

  // R5
  a_r5_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    locked_o |=> locked_o);

  // R9
  a_r9_load_needs_lock: assert property (@(posedge clk) disable iff (rst)
    load_o |-> locked_o);

  // R9
  a_r9_single_cycle: assert property (@(posedge clk) disable iff (rst)
    load_o |=> !load_o);

  // R7
  a_r7_steady_gap: assert property (@(posedge clk) disable iff (rst)
    (load_o && ref_v_q) |-> (since_q == ref_q));

endmodule

bind lpc_centre_sync lpc_centre_sync_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .load_o   (load_o),
  .locked_o (locked_o)
);

// File: tb/lpc_centre_sync_bench.sv
`timescale 1ns/1ps
module lpc_centre_sync_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic load_o;
  logic locked_o;

  int cyc     = 0;
  int n_chk   = 0;
  int n_fail  = 0;
  int lock_at = 32'h7fff_ffff;
  bit mon_en  = 1'b0;
  int exp_q[$];

  lpc_centre_sync #(.SYNC_STAGES(2), .CNT_W(8)) u_lpc_centre_sync (
    .clk      (clk),
    .rst      (rst),
    .en_i     (en),
    .load_o   (load_o),
    .locked_o (locked_o)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // monitor: scoreboard of strobe cycles, plus the lock flag
  always @(negedge clk) begin
    int e;
    if (mon_en) begin
      if (exp_q.size() > 0 && exp_q[0] < cyc) begin
        e = exp_q.pop_front();
        check(1'b0, "R7 missing strobe", -1, e);
      end
      if (load_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected strobe", cyc, -1);
        end else begin
          e = exp_q.pop_front();
          check(e == cyc, "R6 R3 R2 strobe cycle", cyc, e);
        end
      end
      if (cyc == lock_at - 1 || cyc == lock_at) begin
        check(locked_o == (cyc >= lock_at), "R5 lock edge", int'(locked_o), int'(cyc >= lock_at));
      end else if (locked_o != (cyc >= lock_at)) begin
        check(1'b0, "R5 lock level", int'(locked_o), int'(cyc >= lock_at));
      end
    end
  end

  task automatic do_reset();
    mon_en = 1'b0;
    lock_at = 32'h7fff_ffff;
    exp_q.delete();
    rst = 1'b1;
    en  = 1'b0;
    repeat (3) @(negedge clk);
    check(!load_o && !locked_o, "R1 reset state", int'({locked_o, load_o}), 0);
    rst = 1'b0;
  endtask

  // drive en so that it is first sampled high at edge k, held for w edges
  task automatic pulse_at(input int k, input int w);
    @(negedge clk);
    while (cyc < k - 1) @(negedge clk);
    en = 1'b1;
    repeat (w) @(negedge clk);
    en = 1'b0;
  endtask

  // driver: pushes expected strobe cycles while producing the pulse train
  task automatic run_case(input int p, input int pre_gap);
    int w;
    int half;
    int base;
    int last_exp;
    w = (p / 4 < 1) ? 1 : p / 4;
    half = p / 2;
    last_exp = 0;
    do_reset();
    base = cyc + 4;
    mon_en = 1'b1;
    if (pre_gap > 0) begin
      pulse_at(base, w);
      base = base + pre_gap;
      while (cyc < base - 2) @(negedge clk);
      check(!locked_o, "R4 long gap not locked", int'(locked_o), 0);
    end
    lock_at = base + p + 3;
    for (int n = 0; n < 8; n++) begin
      int k;
      int kd;
      k = base + n * p;
      kd = k;
      if (n >= 1) begin
        exp_q.push_back(k + 2 + half);
        last_exp = k + 2 + half;
      end
      if (p >= 4 && n == 4) continue;   // dropped pulse, strobe must stay (R7)
      if (p >= 4 && n == 5) kd = k + 1; // displaced pulse, strobe must not move (R8)
      pulse_at(kd, w);
    end
    while (cyc < last_exp + 1) @(negedge clk);
    mon_en = 1'b0;
    check(exp_q.size() == 0, "R7 R8 all strobes seen", exp_q.size(), 0);
    check(locked_o, "R5 still locked", int'(locked_o), 1);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    run_case(12, 0);
    run_case(7, 0);
    run_case(4, 0);
    run_case(3, 0);
    run_case(2, 0);
    run_case(30, 0);
    run_case(255, 0);
    run_case(9, 300);
    do_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule